// File: doc/BRIEF.md
# Time-Triggered Slot Scheduler with Ping-Pong Buffer Select

This block keeps the local time base of one node on a shared bus that is divided in time. A round is cut into an even number of equal slots, each a fixed number of clock cycles long. A per-slot owner table tells the block which node may drive the bus in each slot. The block compares the owner of the current slot with its own node number and asserts a transmit enable for the slots it owns. It also names which of two send/receive buffer pairs is active: the low bit of the slot number. As a result, a message placed in one buffer is picked up from the opposite-index buffer in the next slot.

A strap input selects the role. A master starts counting on its own as soon as reset is released and flags each of its round starts on a sync-transmit output. A slave stays silent after reset until the first sync event arrives. After that, every sync realigns its round timer. The timer allows for a fixed detection latency, so a sync that is seen one cycle late only shifts the local round by that cycle. The serial bit line is driven from a register: it is the sampled transmit bit in owned slots and the idle level everywhere else. A parameter set with an odd slot count, or with a latency that does not fit in a slot, stops elaboration.

Top module: `tdma_slot_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, slot_o is 0, both strobes and tx_en_o are 0, and tx_line_o is at the idle level 1.
- R2: A slave (master_i = 0) that has not yet seen sync_i high produces no strobes and keeps tx_en_o at 0 and tx_line_o at 1, whatever tx_bit_i does.
- R3: When an idle slave samples sync_i high in cycle k, cycle k+1 shows slot 0 with round_start_o and slot_start_o both high. The next slot_start_o comes SLOT_LEN−SYNC_LAT cycles after that.
- R4: While running, every slot lasts SLOT_LEN cycles. slot_o counts 0 to NUM_SLOTS−1 and wraps to 0, and never shows a value of NUM_SLOTS or above.
- R5: slot_start_o and round_start_o are each one cycle wide. round_start_o is high only together with slot_start_o and slot 0.
- R6: buf_idx_o equals bit 0 of slot_o, so it toggles at every slot boundary, including the wrap from the last slot to slot 0.
- R7: tx_en_o is high exactly when the block is running and the owner of the current slot equals node_id_i. The owner of slot s is owner_tbl_i[s*NODE_W +: NODE_W].
- R8: In a cycle with tx_en_o high, tx_line_o equals tx_bit_i as sampled at the preceding clock edge. In every other cycle it is 1.
- R9: A master starts at slot 0 with round_start_o in the first cycle after reset release. It ignores sync_i, repeats its round every NUM_SLOTS·SLOT_LEN cycles, and pulses sync_tx_o exactly with each of its round starts.
- R10: In a running slave, a sync sampled at an edge reloads the timer to slot 0 at cycle offset SYNC_LAT. This reload takes priority over a slot wrap at the same edge and makes no strobe of its own. An on-time sync leaves the round period unchanged, and a sync one cycle late lengthens it by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | Role strap: 1 master, 0 slave |
| node_id_i | input | NODE_W | This node's number |
| owner_tbl_i | input | NUM_SLOTS*NODE_W | Owner node per slot, slot s in bits s*NODE_W upward |
| sync_i | input | 1 | Detected sync event (slave only) |
| tx_bit_i | input | 1 | Bit to place on the line in owned slots |
| slot_o | output | $clog2(NUM_SLOTS) | Current slot number |
| slot_start_o | output | 1 | First cycle of a slot |
| round_start_o | output | 1 | First cycle of a round |
| buf_idx_o | output | 1 | Active buffer pair |
| tx_en_o | output | 1 | This node owns the current slot |
| tx_line_o | output | 1 | Registered bus line output |
| sync_tx_o | output | 1 | Master sends sync in this cycle |

## Verification
Two functions can meet at the same clock edge: the local wrap of the last cycle of a round and a slave's sync reload. The bench provokes this by sending a sync exactly when the local timer is in the final cycle of a round. It then checks that the reload wins: no round strobe appears, and the next round start comes 2·NUM_SLOTS·SLOT_LEN−SYNC_LAT cycles after the previous one. On-time and one-cycle-late syncs are judged in the same way, by the distance between successive round starts.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    // level held on the bus line by a node that does not own the slot
    localparam logic LINE_IDLE = 1'b1;

    function automatic bit cfg_ok(input int num_slots, input int slot_len, input int sync_lat);
        return (num_slots >= 2) && (num_slots % 2 == 0) && (sync_lat >= 1) && (sync_lat < slot_len);
    endfunction

endpackage

// File: rtl/tdma_slot_timer.sv
module tdma_slot_timer #(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_LEN  = 64,
    parameter int SYNC_LAT  = 2,
    localparam int CYC_W    = $clog2(SLOT_LEN),
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              master_i,
    input  logic              sync_i,
    output logic [SLOT_W-1:0] slot_o,
    output logic [SLOT_W-1:0] slot_nxt_o,
    output logic              run_nxt_o,
    output logic              slot_start_o,
    output logic              round_start_o
);

    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(SLOT_LEN - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [CYC_W-1:0]  CYC_SYNC  = CYC_W'(SYNC_LAT);

    typedef struct packed {
        logic              run;
        logic [CYC_W-1:0]  cyc;
        logic [SLOT_W-1:0] slot;
        logic              sstart;
        logic              rstart;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d        = tmr_q;
        tmr_d.sstart = 1'b0;
        tmr_d.rstart = 1'b0;
        if (!tmr_q.run) begin
            if (master_i) begin
                tmr_d.run    = 1'b1;
                tmr_d.cyc    = '0;
                tmr_d.slot   = '0;
                tmr_d.sstart = 1'b1;
                tmr_d.rstart = 1'b1;
            end else if (sync_i) begin
                // sync reports a round start SYNC_LAT cycles in the past
                tmr_d.run    = 1'b1;
                tmr_d.cyc    = CYC_SYNC;
                tmr_d.slot   = '0;
                tmr_d.sstart = 1'b1;
                tmr_d.rstart = 1'b1;
            end
        end else if (!master_i && sync_i) begin
            // realignment wins over a coincident wrap
            tmr_d.cyc  = CYC_SYNC;
            tmr_d.slot = '0;
        end else if (tmr_q.cyc == CYC_LAST) begin
            tmr_d.cyc    = '0;
            tmr_d.sstart = 1'b1;
            if (tmr_q.slot == SLOT_LAST) begin
                tmr_d.slot   = '0;
                tmr_d.rstart = 1'b1;
            end else begin
                tmr_d.slot = tmr_q.slot + 1'b1;
            end
        end else begin
            tmr_d.cyc = tmr_q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign slot_o        = tmr_q.slot;
    assign slot_nxt_o    = tmr_d.slot;
    assign run_nxt_o     = tmr_d.run;
    assign slot_start_o  = tmr_q.sstart;
    assign round_start_o = tmr_q.rstart;

endmodule

// File: rtl/tdma_owner_match.sv
module tdma_owner_match #(
    parameter int NUM_SLOTS = 8,
    parameter int NODE_W    = 3,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic [NUM_SLOTS*NODE_W-1:0] owner_tbl_i,
    input  logic [NODE_W-1:0]           node_id_i,
    input  logic [SLOT_W-1:0]           slot_i,
    output logic                        own_o
);

    logic [NUM_SLOTS-1:0] hit;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        assign hit[s] = (owner_tbl_i[s*NODE_W +: NODE_W] == node_id_i);
    end

    assign own_o = hit[slot_i];

endmodule

// File: rtl/tdma_line_drive.sv
module tdma_line_drive
    import tdma_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_nxt_i,
    input  logic bit_i,
    output logic en_o,
    output logic line_o
);

    typedef struct packed {
        logic en;
        logic line;
    } drv_t;

    drv_t drv_d, drv_q;

    always_comb begin
        drv_d.en   = en_nxt_i;
        drv_d.line = en_nxt_i ? bit_i : LINE_IDLE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            drv_q <= '{en: 1'b0, line: LINE_IDLE};
        end else begin
            drv_q <= drv_d;
        end
    end

    assign en_o   = drv_q.en;
    assign line_o = drv_q.line;

endmodule

// File: rtl/tdma_slot_sched.sv
module tdma_slot_sched
    import tdma_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_LEN  = 64,
    parameter int SYNC_LAT  = 2,
    parameter int NODE_W    = 3,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        master_i,
    input  logic [NODE_W-1:0]           node_id_i,
    input  logic [NUM_SLOTS*NODE_W-1:0] owner_tbl_i,
    input  logic                        sync_i,
    input  logic                        tx_bit_i,
    output logic [SLOT_W-1:0]           slot_o,
    output logic                        slot_start_o,
    output logic                        round_start_o,
    output logic                        buf_idx_o,
    output logic                        tx_en_o,
    output logic                        tx_line_o,
    output logic                        sync_tx_o
);

    if (!cfg_ok(NUM_SLOTS, SLOT_LEN, SYNC_LAT)) begin : g_bad_cfg
        $error("slot scheduler: slot count must be even and sync latency must lie in 1..SLOT_LEN-1");
    end

    logic [SLOT_W-1:0] slot_nxt;
    logic              run_nxt;
    logic              own_nxt;

    tdma_slot_timer #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_LEN  (SLOT_LEN),
        .SYNC_LAT  (SYNC_LAT)
    ) u_timer (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .master_i      (master_i),
        .sync_i        (sync_i),
        .slot_o        (slot_o),
        .slot_nxt_o    (slot_nxt),
        .run_nxt_o     (run_nxt),
        .slot_start_o  (slot_start_o),
        .round_start_o (round_start_o)
    );

    tdma_owner_match #(
        .NUM_SLOTS (NUM_SLOTS),
        .NODE_W    (NODE_W)
    ) u_owner (
        .owner_tbl_i (owner_tbl_i),
        .node_id_i   (node_id_i),
        .slot_i      (slot_nxt),
        .own_o       (own_nxt)
    );

    tdma_line_drive u_drive (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_nxt_i (run_nxt && own_nxt),
        .bit_i    (tx_bit_i),
        .en_o     (tx_en_o),
        .line_o   (tx_line_o)
    );

    assign buf_idx_o = slot_o[0];
    assign sync_tx_o = master_i && round_start_o;

endmodule

// File: rtl/tdma_sched_chk.sv
module tdma_sched_chk #(
    parameter int NUM_SLOTS = 8,
    parameter int NODE_W    = 3,
    localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
    input logic                        clk_i,
    input logic                        rst_ni,
    input logic                        master_i,
    input logic [NODE_W-1:0]           node_id_i,
    input logic [NUM_SLOTS*NODE_W-1:0] owner_tbl_i,
    input logic [SLOT_W-1:0]           slot_o,
    input logic                        slot_start_o,
    input logic                        round_start_o,
    input logic                        buf_idx_o,
    input logic                        tx_en_o,
    input logic                        tx_line_o,
    input logic                        sync_tx_o
);

    assert_slot_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(slot_o) < NUM_SLOTS);

    assert_slot_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_start_o && !round_start_o) |-> (slot_o == $past(slot_o) + 1'b1));

    assert_sstart_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_start_o |=> !slot_start_o);

    assert_rstart_in_slot0_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        round_start_o |-> (slot_start_o && slot_o == '0));

    assert_buf_flip_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_start_o && ($past(slot_o) != slot_o || int'($past(slot_o)) == NUM_SLOTS - 1)
         && $past(slot_start_o) == 1'b0 && $past(rst_ni)) |-> (buf_idx_o != $past(buf_idx_o)));

    assert_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_en_o |-> (owner_tbl_i[slot_o*NODE_W +: NODE_W] == node_id_i));

    assert_line_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !tx_en_o |-> tx_line_o);

    assert_sync_tx_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_tx_o |-> (round_start_o && master_i));

endmodule

bind tdma_slot_sched tdma_sched_chk #(
    .NUM_SLOTS (NUM_SLOTS),
    .NODE_W    (NODE_W)
) u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .master_i      (master_i),
    .node_id_i     (node_id_i),
    .owner_tbl_i   (owner_tbl_i),
    .slot_o        (slot_o),
    .slot_start_o  (slot_start_o),
    .round_start_o (round_start_o),
    .buf_idx_o     (buf_idx_o),
    .tx_en_o       (tx_en_o),
    .tx_line_o     (tx_line_o),
    .sync_tx_o     (sync_tx_o)
);

// File: tb/test_tdma_slot_sched.sv
module test_tdma_slot_sched;

    localparam int NS  = 4;
    localparam int T   = 6;
    localparam int LAT = 2;
    localparam int W   = 2;
    localparam int RND = NS * T;
    // owners: slot0 -> 0, slot1 -> 1, slot2 -> 1, slot3 -> 2
    localparam logic [NS*W-1:0] TBL = {2'd2, 2'd1, 2'd1, 2'd0};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          master = 1'b0;
    logic [W-1:0]  node_id = 2'd1;
    logic          sync = 1'b0;
    logic          tx_bit = 1'b0;
    logic [1:0]    slot;
    logic          sstart, rstart, bufi, txen, line, synctx;

    tdma_slot_sched #(
        .NUM_SLOTS (NS),
        .SLOT_LEN  (T),
        .SYNC_LAT  (LAT),
        .NODE_W    (W)
    ) i_tdma_slot_sched (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .master_i      (master),
        .node_id_i     (node_id),
        .owner_tbl_i   (TBL),
        .sync_i        (sync),
        .tx_bit_i      (tx_bit),
        .slot_o        (slot),
        .slot_start_o  (sstart),
        .round_start_o (rstart),
        .buf_idx_o     (bufi),
        .tx_en_o       (txen),
        .tx_line_o     (line),
        .sync_tx_o     (synctx)
    );

    int  checks = 0;
    int  fails  = 0;
    int  cyc_cnt = 0;
    bit  cmp_on = 1'b0;
    bit  done = 1'b0;

    // behavioural reference: one position counter over the whole round
    bit  m_run = 1'b0;
    int  m_pos = 0;
    bit  m_ss = 1'b0, m_rs = 1'b0, m_en = 1'b0, m_line = 1'b1;

    function automatic int owner_of(int s);
        return int'(TBL[s*W +: W]);
    endfunction

    always @(posedge clk) begin : ref_model
        cyc_cnt++;
        if (!rst_n) begin
            m_run = 1'b0; m_pos = 0; m_ss = 1'b0; m_rs = 1'b0;
        end else if (master) begin
            if (!m_run) begin
                m_run = 1'b1; m_pos = 0; m_ss = 1'b1; m_rs = 1'b1;
            end else begin
                m_pos = (m_pos + 1) % RND;
                m_ss = (m_pos % T == 0);
                m_rs = (m_pos == 0);
            end
        end else if (sync) begin
            m_ss = !m_run; m_rs = !m_run;
            m_run = 1'b1; m_pos = LAT;
        end else if (m_run) begin
            m_pos = (m_pos + 1) % RND;
            m_ss = (m_pos % T == 0);
            m_rs = (m_pos == 0);
        end else begin
            m_ss = 1'b0; m_rs = 1'b0;
        end
        m_en   = rst_n && m_run && (owner_of(m_pos / T) == int'(node_id));
        m_line = m_en ? tx_bit : 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc_cnt);
        end
    endtask

    always @(negedge clk) begin : compare
        if (cmp_on && !done) begin
            int es;
            es = m_run ? m_pos / T : 0;
            check(int'(slot) == es, "R4 slot", int'(slot), es);
            check(sstart == m_ss, "R5 slot_start", int'(sstart), int'(m_ss));
            check(rstart == m_rs, "R3 round_start", int'(rstart), int'(m_rs));
            check(int'(bufi) == es % 2, "R6 buf_idx", int'(bufi), es % 2);
            check(txen == m_en, "R7 tx_en", int'(txen), int'(m_en));
            check(line == m_line, "R8 tx_line", int'(line), int'(m_line));
            check(synctx == (master && m_rs), "R9 sync_tx", int'(synctx), int'(master && m_rs));
        end
    end

    always @(negedge clk) if (!done) tx_bit <= 1'($urandom_range(0, 1));

    task automatic sync_at(input int p);
        do @(negedge clk); while (!(m_run && m_pos == p));
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
    endtask

    task automatic wait_rs(output int t);
        do @(negedge clk); while (!rstart);
        t = cyc_cnt;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_cnt, 0);
        finish_run();
    end

    initial begin : stim
        int t0, t1, t2, t3, n_strobe, t_first, t_ss;
        bit line_hi;
        @(negedge clk);
        // R1: reset values while reset held
        check(slot == 0 && !sstart && !rstart && !txen && line, "R1 reset state", int'({sstart, rstart, txen, line}), 1);
        @(posedge clk);
        cmp_on = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(slot == 0 && !sstart && !rstart && !txen && line, "R1 after release", int'({sstart, rstart, txen, line}), 1);

        // R2: slave idle without sync
        n_strobe = 0; line_hi = 1'b1;
        repeat (30) begin
            @(negedge clk);
            n_strobe += int'(sstart) + int'(rstart) + int'(txen);
            line_hi &= line;
        end
        check(n_strobe == 0, "R2 idle strobes", n_strobe, 0);
        check(line_hi, "R2 idle line", int'(line_hi), 1);

        // R3: first sync
        @(negedge clk);
        sync = 1'b1;
        @(negedge clk);
        sync = 1'b0;
        t_first = cyc_cnt;
        check(rstart && sstart && slot == 0, "R3 first sync strobes", int'({rstart, sstart}), 3);
        do @(negedge clk); while (!sstart);
        t_ss = cyc_cnt;
        check(t_ss - t_first == T - LAT, "R3 first slot length", t_ss - t_first, T - LAT);

        // R10: on-time sync keeps the period
        wait_rs(t0);
        sync_at(LAT - 1);
        wait_rs(t1);
        check(t1 - t0 == RND, "R10 on-time sync period", t1 - t0, RND);
        // R10: late sync adds one cycle
        sync_at(LAT);
        wait_rs(t2);
        check(t2 - t1 == RND + 1, "R10 late sync period", t2 - t1, RND + 1);
        // R10: sync colliding with the round wrap takes priority
        sync_at(RND - 1);
        wait_rs(t3);
        check(t3 - t2 == 2 * RND - LAT, "R10 sync at wrap", t3 - t2, 2 * RND - LAT);
        repeat (RND) @(negedge clk);

        // other node id, free running
        node_id = 2'd2;
        repeat (2 * RND) @(negedge clk);

        // R9: master mode with noise on sync_i
        rst_n = 1'b0;
        master = 1'b1;
        node_id = 2'd0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rstart && synctx && slot == 0, "R9 master self start", int'({rstart, synctx}), 3);
        t0 = cyc_cnt;
        for (int r = 0; r < 3; r++) begin
            do begin
                @(negedge clk);
                sync = ($urandom_range(0, 3) == 0);
            end while (!rstart);
            t1 = cyc_cnt;
            check(t1 - t0 == RND, "R9 master period", t1 - t0, RND);
            t0 = t1;
        end
        sync = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule